// File: doc/BRIEF.md
# Slot-Scheduled Stream Link Multiplexer

This block shares one point-to-point link among several periodic data streams. The link carries one 64-bit word in every core clock cycle. Cycles are grouped into frames of 1 to 16 slots. A programmable slot table names the stream that owns each slot. A stream's share of the link is set by how many slots of the frame name it. Spreading those slots through the frame, for example alternating two streams, keeps the buffering at each end small.

On the transmit side, each stream has an input queue. In every slot, the block takes the head word of the owning stream and places it on the link. Stream identity is never written into the data. It travels on separate control lines: a valid flag, the slot index and a frame-start pulse at slot 0. A slot whose owner has nothing to send goes out idle, and no other stream may use it.

On the receive side, the block keeps its own slot counter. The frame-start pulse realigns that counter. The block looks up the owner in the same table and steers each valid word into that stream's output queue. An optional packing mode puts two 30-bit pixels of one stream into a single link word and splits them apart again at the receiver.

Top module: `tdma_link`

## Requirements
- R1: The transmit slot index starts at 0, goes up by one every cycle and returns to 0 after the last active slot. `lnk_sof` is high exactly in the cycles where `lnk_slot` is 0, so a frame of N active slots repeats every N cycles.
- R2: A write with `cfg_tbl_we` stores stream `cfg_tbl_sid` as the owner of slot `cfg_tbl_addr`. A write with `cfg_len_we` sets the number of active slots to `cfg_len_m1`+1. After reset, all 16 entries name stream 0 and the frame length is 1.
- R3: When the owner of the current slot has a word queued, the next cycle shows `lnk_valid`=1 and the slot index on `lnk_slot`. Words of one stream leave in the order they were accepted.
- R4: When the owner of the current slot has too few words queued, that cycle goes out with `lnk_valid`=0 and `lnk_data`=0. Queued words of other streams stay where they are.
- R5: With packing off, no header or trailer is added. The 64-bit word delivered at the receiver equals the word pushed at the transmitter.
- R6: With `cfg_pack`=1, one slot carries two pixels of its owner. The older pixel goes in bits [29:0], the newer one in bits [59:30], and bits [63:60] are 0. A slot whose owner has fewer than two pixels queued goes out idle.
- R7: The receiver slot counter is forced to 0 when `lnk_sof` arrives and otherwise steps with the same wrap as the transmitter. Each valid word goes to the output queue of the stream that the table names for that slot.
- R8: With packing on, the receiver stores the pixel from bits [29:0] first and the pixel from bits [59:30] second. Both are zero-extended to 64 bits.
- R9: A word that arrives for a stream whose output queue lacks room is dropped, and that stream's bit in `ovf` is set. The bit stays set until reset. Other streams' queues and flags are unaffected.
- R10: After reset, `lnk_valid`, `ovf` and `in_full` are 0 and every `out_empty` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_tbl_we | input | 1 | Write enable for a slot table entry |
| cfg_tbl_addr | input | 4 | Slot index to write |
| cfg_tbl_sid | input | 2 | Owning stream for that slot |
| cfg_len_we | input | 1 | Write enable for the frame length |
| cfg_len_m1 | input | 4 | Number of active slots minus one |
| cfg_pack | input | 1 | Pixel packing mode |
| in_push | input | NS | Per-stream push into the transmit queue; ignored while full |
| in_data | input | NS*64 | Per-stream push data, stream s at bits [64s+63:64s] |
| in_full | output | NS | Per-stream transmit queue full |
| lnk_data | output | 64 | Link word sent |
| lnk_valid | output | 1 | Link word valid |
| lnk_slot | output | 4 | Slot index of the word sent |
| lnk_sof | output | 1 | Frame start, high at slot 0 |
| rl_data | input | 64 | Link word received |
| rl_valid | input | 1 | Received word valid |
| rl_sof | input | 1 | Received frame start |
| out_pop | input | NS | Per-stream pop from the receive queue |
| out_data | output | NS*64 | Per-stream receive queue head |
| out_empty | output | NS | Per-stream receive queue empty |
| ovf | output | NS | Per-stream sticky receive overflow |

## Verification
The bench loops the link back to the receiver. It aims at slots whose owner is idle while other streams hold data: a design that lets another stream take the slot would put that stream's words in slots that the table does not give it. In packing mode, the bench feeds an odd number of pixels. A design that sends a half-filled word would deliver a pixel early, with a zero partner. A frame of three slots with uneven shares exposes wrap errors that a two-slot frame hides. Overfilling one receive queue shows whether a design overwrites stored words, drops the wrong ones, flags the wrong stream or clears the flag on its own.

// File: rtl/tdma_pkg.sv
// Shared constants and helpers for the slot-scheduled stream link.
package tdma_pkg;
    localparam int LINK_W = 64;

    // Number of queue entries one slot consumes or produces.
    function automatic logic [1:0] words_per_slot(input logic pack);
        return pack ? 2'd2 : 2'd1;
    endfunction
endpackage

// File: rtl/tdma_fifo2.sv
// Queue that can accept up to two words and release up to two words per cycle.
// The two oldest entries are visible at all times.
// Assumes: DEPTH is a power of two, at least 2. The caller never pushes
// beyond free space and never pops more than are held.
module tdma_fifo2 #(
    parameter int W     = 64,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  wd0,
    input  logic [W-1:0]  wd1,
    input  logic [1:0]    pop_n,
    output logic [W-1:0]  rd0,
    output logic [W-1:0]  rd1,
    output logic [CW-1:0] cnt
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    assign rd0 = mem[rp];
    assign rd1 = mem[rp + AW'(1)];

    // Storage write, one or two entries.
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wp] <= wd0;
        if (push_n == 2'd2) mem[wp + AW'(1)] <= wd1;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            wp  <= wp + AW'(push_n);
            rp  <= rp + AW'(pop_n);
            cnt <= cnt + CW'(push_n) - CW'(pop_n);
        end
    end
endmodule

// File: rtl/tdma_slot_tbl.sv
// Slot ownership table and frame length, with one write port and two read ports
// (transmit and receive). Reset gives every slot to stream 0 and a one-slot frame.
// Assumes: NS >= 2.
module tdma_slot_tbl #(
    parameter int NS    = 4,
    parameter int DEPTH = 16,
    localparam int SW   = $clog2(NS),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [SW-1:0] wsid,
    input  logic          len_we,
    input  logic [PW-1:0] len_in,
    input  logic [PW-1:0] ra_idx,
    output logic [SW-1:0] ra_sid,
    input  logic [PW-1:0] rb_idx,
    output logic [SW-1:0] rb_sid,
    output logic [PW-1:0] len_m1
);
    logic [SW-1:0] tbl [DEPTH];

    assign ra_sid = tbl[ra_idx];
    assign rb_sid = tbl[rb_idx];

    // Table and length register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
            len_m1 <= '0;
        end else begin
            if (we)     tbl[waddr] <= wsid;
            if (len_we) len_m1     <= len_in;
        end
    end
endmodule

// File: rtl/tdma_tx.sv
// Transmit scheduler: walks the slot table, takes the owner's head word(s)
// and registers the link word plus its sideband lines.
// Assumes: owner is the table entry at slot_ptr, valid in the same cycle.
module tdma_tx
    import tdma_pkg::*;
#(
    parameter int NS    = 4,
    parameter int DEPTH = 16,
    parameter int FD    = 4,
    parameter int PIX_W = 30,
    localparam int SW   = $clog2(NS),
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(FD) + 1,
    localparam int PAD  = LINK_W - 2 * PIX_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [PW-1:0]                     len_m1,
    input  logic                              pack,
    input  logic [SW-1:0]                     owner,
    input  logic [NS-1:0][LINK_W-1:0]         head0,
    input  logic [NS-1:0][LINK_W-1:0]         head1,
    input  logic [NS-1:0][CW-1:0]             qcnt,
    output logic [PW-1:0]                     slot_ptr,
    output logic [NS-1:0][1:0]                pop_n,
    output logic [LINK_W-1:0]                 lnk_data,
    output logic                              lnk_valid,
    output logic [PW-1:0]                     lnk_slot,
    output logic                              lnk_sof
);
    logic [1:0]        need;
    logic              ready;
    logic [LINK_W-1:0] word;

    // Decide whether the owner can fill this slot and form the word.
    always_comb begin
        need  = words_per_slot(pack);
        ready = qcnt[owner] >= CW'(need);
        word  = pack ? {{PAD{1'b0}}, head1[owner][PIX_W-1:0], head0[owner][PIX_W-1:0]}
                     : head0[owner];
        for (int s = 0; s < NS; s++)
            pop_n[s] = (ready && owner == SW'(s)) ? need : 2'd0;
    end

    // Slot pointer and registered link outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_ptr  <= '0;
            lnk_data  <= '0;
            lnk_valid <= 1'b0;
            lnk_slot  <= '0;
            lnk_sof   <= 1'b0;
        end else begin
            slot_ptr  <= (slot_ptr >= len_m1) ? '0 : slot_ptr + PW'(1);
            lnk_valid <= ready;
            lnk_data  <= ready ? word : '0;
            lnk_slot  <= slot_ptr;
            lnk_sof   <= (slot_ptr == '0);
        end
    end
endmodule

// File: rtl/tdma_rx.sv
// Receive steering: keeps a slot counter realigned by frame start, finds the
// owner and pushes one or two entries into its queue, or flags an overflow.
// Assumes: owner is the table entry at cur_slot, valid in the same cycle.
module tdma_rx
    import tdma_pkg::*;
#(
    parameter int NS    = 4,
    parameter int DEPTH = 16,
    parameter int FD    = 4,
    parameter int PIX_W = 30,
    localparam int SW   = $clog2(NS),
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(FD) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PW-1:0]             len_m1,
    input  logic                      pack,
    input  logic [LINK_W-1:0]         rl_data,
    input  logic                      rl_valid,
    input  logic                      rl_sof,
    input  logic [SW-1:0]             owner,
    input  logic [NS-1:0][CW-1:0]     qcnt,
    output logic [PW-1:0]             cur_slot,
    output logic [NS-1:0][1:0]        push_n,
    output logic [LINK_W-1:0]         wd0,
    output logic [LINK_W-1:0]         wd1,
    output logic [NS-1:0]             ovf
);
    logic [PW-1:0] ptr;
    logic [1:0]    need;
    logic          room;

    // Slot alignment, room test and unpacking.
    always_comb begin
        cur_slot = rl_sof ? '0 : ptr;
        need     = words_per_slot(pack);
        room     = (CW'(FD) - qcnt[owner]) >= CW'(need);
        wd0      = pack ? LINK_W'(rl_data[PIX_W-1:0]) : rl_data;
        wd1      = LINK_W'(rl_data[2*PIX_W-1:PIX_W]);
        for (int s = 0; s < NS; s++)
            push_n[s] = (rl_valid && room && owner == SW'(s)) ? need : 2'd0;
    end

    // Receive slot counter and sticky overflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            ovf <= '0;
        end else begin
            ptr <= (cur_slot >= len_m1) ? '0 : cur_slot + PW'(1);
            if (rl_valid && !room) ovf[owner] <= 1'b1;
        end
    end
endmodule

// File: rtl/tdma_link.sv
// Top of the slot-scheduled link: per-stream transmit and receive queues,
// the shared slot table, the transmit scheduler and the receive steering.
// Assumes: both link ends run from this clock; the table is not rewritten
// while words of the affected slots are in flight.
module tdma_link
    import tdma_pkg::*;
#(
    parameter int NS    = 4,
    parameter int DEPTH = 16,
    parameter int FD    = 4,
    parameter int PIX_W = 30,
    localparam int SW   = $clog2(NS),
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(FD) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_tbl_we,
    input  logic [PW-1:0]        cfg_tbl_addr,
    input  logic [SW-1:0]        cfg_tbl_sid,
    input  logic                 cfg_len_we,
    input  logic [PW-1:0]        cfg_len_m1,
    input  logic                 cfg_pack,
    input  logic [NS-1:0]        in_push,
    input  logic [NS*LINK_W-1:0] in_data,
    output logic [NS-1:0]        in_full,
    output logic [LINK_W-1:0]    lnk_data,
    output logic                 lnk_valid,
    output logic [PW-1:0]        lnk_slot,
    output logic                 lnk_sof,
    input  logic [LINK_W-1:0]    rl_data,
    input  logic                 rl_valid,
    input  logic                 rl_sof,
    input  logic [NS-1:0]        out_pop,
    output logic [NS*LINK_W-1:0] out_data,
    output logic [NS-1:0]        out_empty,
    output logic [NS-1:0]        ovf
);
    logic [PW-1:0]             tx_ptr, rx_slot, len_m1;
    logic [SW-1:0]             tx_owner, rx_owner;
    logic [NS-1:0][LINK_W-1:0] txh0, txh1, rxh0, rxh1;
    logic [NS-1:0][CW-1:0]     txc, rxc;
    logic [NS-1:0][1:0]        txpop, rxpush;
    logic [LINK_W-1:0]         rwd0, rwd1;

    tdma_slot_tbl #(.NS(NS), .DEPTH(DEPTH)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_tbl_we), .waddr(cfg_tbl_addr), .wsid(cfg_tbl_sid),
        .len_we(cfg_len_we), .len_in(cfg_len_m1),
        .ra_idx(tx_ptr), .ra_sid(tx_owner),
        .rb_idx(rx_slot), .rb_sid(rx_owner),
        .len_m1(len_m1)
    );

    // One transmit and one receive queue per stream.
    for (genvar s = 0; s < NS; s++) begin : g_stream
        assign in_full[s]   = (txc[s] == CW'(FD));
        assign out_empty[s] = (rxc[s] == '0);
        assign out_data[s*LINK_W +: LINK_W] = rxh0[s];

        tdma_fifo2 #(.W(LINK_W), .DEPTH(FD)) u_txq (
            .clk(clk), .rst_n(rst_n),
            .push_n({1'b0, in_push[s] && !in_full[s]}),
            .wd0(in_data[s*LINK_W +: LINK_W]), .wd1('0),
            .pop_n(txpop[s]),
            .rd0(txh0[s]), .rd1(txh1[s]), .cnt(txc[s])
        );

        tdma_fifo2 #(.W(LINK_W), .DEPTH(FD)) u_rxq (
            .clk(clk), .rst_n(rst_n),
            .push_n(rxpush[s]), .wd0(rwd0), .wd1(rwd1),
            .pop_n({1'b0, out_pop[s] && !out_empty[s]}),
            .rd0(rxh0[s]), .rd1(rxh1[s]), .cnt(rxc[s])
        );
    end

    tdma_tx #(.NS(NS), .DEPTH(DEPTH), .FD(FD), .PIX_W(PIX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .len_m1(len_m1), .pack(cfg_pack),
        .owner(tx_owner), .head0(txh0), .head1(txh1), .qcnt(txc),
        .slot_ptr(tx_ptr), .pop_n(txpop),
        .lnk_data(lnk_data), .lnk_valid(lnk_valid),
        .lnk_slot(lnk_slot), .lnk_sof(lnk_sof)
    );

    tdma_rx #(.NS(NS), .DEPTH(DEPTH), .FD(FD), .PIX_W(PIX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .len_m1(len_m1), .pack(cfg_pack),
        .rl_data(rl_data), .rl_valid(rl_valid), .rl_sof(rl_sof),
        .owner(rx_owner), .qcnt(rxc),
        .cur_slot(rx_slot), .push_n(rxpush),
        .wd0(rwd0), .wd1(rwd1), .ovf(ovf)
    );
endmodule

// File: rtl/tdma_link_chk.sv
// Property checker for tdma_link, attached by bind below.
module tdma_link_chk #(
    parameter int NS = 4,
    parameter int PW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_pack,
    input logic [63:0]       lnk_data,
    input logic              lnk_valid,
    input logic [PW-1:0]     lnk_slot,
    input logic [NS-1:0]     ovf,
    input logic [NS-1:0][1:0] txpop
);
    logic [NS-1:0] popping;

    // Which streams release words this cycle.
    always_comb
        for (int s = 0; s < NS; s++) popping[s] = (txpop[s] != 2'd0);

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lnk_slot == '0 || lnk_slot == $past(lnk_slot) + PW'(1))); // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_valid |-> lnk_data == '0); // R4
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(popping)); // R4
    AST_PACK_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && $past(cfg_pack)) |-> lnk_data[63:60] == 4'd0); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf) |=> ((ovf & $past(ovf)) == $past(ovf))); // R9
endmodule

bind tdma_link tdma_link_chk #(.NS(NS), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_pack(cfg_pack),
    .lnk_data(lnk_data), .lnk_valid(lnk_valid), .lnk_slot(lnk_slot),
    .ovf(ovf), .txpop(txpop)
);

// File: tb/tdma_link_tb_top.sv
// Directed bench for tdma_link with the link looped back to the receiver.
module tdma_link_tb_top;
    localparam int NS = 4;
    localparam int LW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_tbl_we = 1'b0, cfg_len_we = 1'b0, cfg_pack = 1'b0;
    logic [3:0] cfg_tbl_addr = '0, cfg_len_m1 = '0;
    logic [1:0] cfg_tbl_sid = '0;
    logic [NS-1:0] in_push = '0, out_pop = '0;
    logic [NS*LW-1:0] in_data = '0;
    logic [NS-1:0] in_full, out_empty, ovf;
    logic [NS*LW-1:0] out_data;
    logic [LW-1:0] lnk_data;
    logic lnk_valid, lnk_sof;
    logic [3:0] lnk_slot;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit mon_en = 1'b0;
    bit bpack = 1'b0;
    logic [1:0] btbl [16];
    logic [63:0] expq [NS][32];
    int wr_i [NS], rd_i [NS];

    always #2 clk = ~clk;

    tdma_link dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_tbl_we(cfg_tbl_we), .cfg_tbl_addr(cfg_tbl_addr), .cfg_tbl_sid(cfg_tbl_sid),
        .cfg_len_we(cfg_len_we), .cfg_len_m1(cfg_len_m1), .cfg_pack(cfg_pack),
        .in_push(in_push), .in_data(in_data), .in_full(in_full),
        .lnk_data(lnk_data), .lnk_valid(lnk_valid), .lnk_slot(lnk_slot), .lnk_sof(lnk_sof),
        .rl_data(lnk_data), .rl_valid(lnk_valid), .rl_sof(lnk_sof),
        .out_pop(out_pop), .out_data(out_data), .out_empty(out_empty), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Link monitor: every valid word must belong to the slot's owner (R3, R4, R6).
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            check(lnk_sof == (lnk_slot == 4'd0), "R1", "sof vs slot", 64'(lnk_sof), 64'(lnk_slot == 4'd0));
            if (lnk_valid && !bpack)
                check(lnk_data[63:56] == 8'(btbl[lnk_slot]), "R3", "word owner", 64'(lnk_data[63:56]), 64'(btbl[lnk_slot]));
            if (lnk_valid && bpack)
                check(lnk_data[63:60] == 4'd0 && lnk_data[59:56] == 4'(btbl[lnk_slot])
                      && lnk_data[29:26] == 4'(btbl[lnk_slot]), "R6", "packed layout", lnk_data, 64'(btbl[lnk_slot]));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_slot(input int idx, input int sid);
        cfg_tbl_we = 1'b1; cfg_tbl_addr = 4'(idx); cfg_tbl_sid = 2'(sid);
        btbl[idx] = 2'(sid);
        @(negedge clk);
        cfg_tbl_we = 1'b0;
    endtask

    task automatic set_len(input int n);
        cfg_len_we = 1'b1; cfg_len_m1 = 4'(n - 1);
        @(negedge clk);
        cfg_len_we = 1'b0;
    endtask

    task automatic push(input int s, input logic [63:0] d, input bit record);
        in_push[s] = 1'b1;
        in_data[s*LW +: LW] = d;
        if (record) begin
            expq[s][wr_i[s]] = d;
            wr_i[s]++;
        end
        @(negedge clk);
        in_push[s] = 1'b0;
    endtask

    task automatic drain(input int s, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            check(!out_empty[s], req, $sformatf("stream %0d has word %0d", s, k), 64'(out_empty[s]), 64'd0);
            check(out_data[s*LW +: LW] == expq[s][rd_i[s]], req, $sformatf("stream %0d word %0d", s, k),
                  out_data[s*LW +: LW], expq[s][rd_i[s]]);
            rd_i[s]++;
            out_pop[s] = 1'b1;
            @(negedge clk);
            out_pop[s] = 1'b0;
        end
    endtask

    function automatic logic [63:0] wtag(input int s, input int seq);
        return {8'(s), 24'h0, 32'(seq)};
    endfunction

    function automatic logic [63:0] ptag(input int s, input int seq);
        return 64'({4'(s), 26'(seq)});
    endfunction

    task automatic t_reset;
        check(lnk_valid == 1'b0, "R10", "lnk_valid after reset", 64'(lnk_valid), 64'd0);
        check(out_empty == '1, "R10", "out_empty after reset", 64'(out_empty), 64'hF);
        check(ovf == '0, "R10", "ovf after reset", 64'(ovf), 64'd0);
        check(in_full == '0, "R10", "in_full after reset", 64'(in_full), 64'd0);
    endtask

    task automatic t_interleave;
        mon_en = 1'b0;
        set_slot(0, 0); set_slot(1, 1); set_len(2);
        idle(2); mon_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            push(0, wtag(0, k), 1'b1);
            push(1, wtag(1, 100 + k), 1'b1);
        end
        idle(20);
        drain(0, 4, "R5"); // R5 R7: payload unchanged, steered to its own stream
        drain(1, 4, "R7");
    endtask

    task automatic t_frame3;
        int gap;
        int slots [4];
        mon_en = 1'b0;
        set_slot(0, 1); set_slot(1, 0); set_slot(2, 0); set_len(3);
        idle(2); mon_en = 1'b1;
        while (!lnk_sof) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            slots[k] = int'(lnk_slot);
            @(negedge clk);
        end
        check(slots[0] == 0 && slots[1] == 1 && slots[2] == 2 && slots[3] == 0, "R1", "slot order",
              64'({slots[1], slots[2]}), 64'({32'd1, 32'd2}));
        gap = 1;
        while (!lnk_sof) begin gap++; @(negedge clk); end
        check(gap == 3, "R1", "frame period", 64'(gap), 64'd3);
        for (int k = 0; k < 3; k++) begin
            push(0, wtag(0, 10 + k), 1'b1);
            push(1, wtag(1, 110 + k), 1'b1);
        end
        idle(20);
        drain(0, 3, "R2");
        drain(1, 3, "R2");
    endtask

    task automatic t_no_steal;
        int vcount;
        mon_en = 1'b0;
        set_slot(0, 0); set_slot(1, 0); set_slot(2, 0); set_slot(3, 1); set_len(4);
        idle(2); mon_en = 1'b1;
        push(1, wtag(1, 200), 1'b1);
        push(1, wtag(1, 201), 1'b1);
        vcount = 0;
        for (int k = 0; k < 20; k++) begin
            if (lnk_valid) vcount++;
            @(negedge clk);
        end
        check(vcount == 2, "R4", "valid words over window", 64'(vcount), 64'd2);
        check(out_empty[0] == 1'b1, "R4", "stream 0 got nothing", 64'(out_empty[0]), 64'd1);
        drain(1, 2, "R3");
    endtask

    task automatic t_pack;
        mon_en = 1'b0;
        cfg_pack = 1'b1; bpack = 1'b1;
        set_slot(0, 0); set_slot(1, 1); set_len(2);
        idle(2); mon_en = 1'b1;
        for (int k = 0; k < 4; k++) push(0, ptag(0, 300 + k), 1'b1);
        for (int k = 0; k < 3; k++) push(1, ptag(1, 400 + k), 1'b1);
        idle(20);
        drain(0, 4, "R8");
        drain(1, 2, "R8");
        check(out_empty[1] == 1'b1, "R6", "odd pixel held back", 64'(out_empty[1]), 64'd1);
        push(1, ptag(1, 403), 1'b1);
        idle(20);
        drain(1, 2, "R6");
        mon_en = 1'b0;
        cfg_pack = 1'b0; bpack = 1'b0;
        idle(2);
    endtask

    task automatic t_overflow;
        mon_en = 1'b0;
        set_slot(0, 2); set_len(1);
        idle(2); mon_en = 1'b1;
        for (int k = 0; k < 4; k++) push(2, wtag(2, 500 + k), 1'b1);
        idle(10);
        check(ovf == '0, "R9", "no flag while room", 64'(ovf), 64'd0);
        push(2, wtag(2, 504), 1'b0);
        push(2, wtag(2, 505), 1'b0);
        idle(10);
        check(ovf == 4'b0100, "R9", "flag only stream 2", 64'(ovf), 64'h4);
        drain(2, 4, "R9");
        check(out_empty[2] == 1'b1, "R9", "extra words dropped", 64'(out_empty[2]), 64'd1);
        check(ovf == 4'b0100, "R9", "flag sticky", 64'(ovf), 64'h4);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) btbl[i] = 2'd0;
        for (int s = 0; s < NS; s++) begin wr_i[s] = 0; rd_i[s] = 0; end
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_interleave();
        t_frame3();
        t_no_steal();
        t_pack();
        t_overflow();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule